// File: doc/BRIEF.md
# Quarter-Rate Raster Sync Timing Generator

This block produces the scan timing for an 800x600, 60 Hz raster. Its horizontal axis runs at one quarter of the standard pixel rate. A 40 MHz clock is divided by four into a 10 MHz pixel step. A column counter walks each scan line in 264 steps, and 200 of those steps are visible. The vertical axis keeps the full 600-line standard structure, 628 lines per frame. The block drives horizontal and vertical sync, a display-active flag, and the current column and line. No pixel data passes through it.

Every region edge is found by an exact match against the next count value. The result is stored in a flag register, so the sync and active outputs come straight from flip-flops and do not show counter-transition glitches. An enable input freezes the whole timing chain while it is low. A synchronous reset returns the chain to the first visible pixel of a frame.

Top module: `scan_timing_gen`

## Requirements
- R1: The counters advance once every 4 clock cycles in which en_i is high. The column moves by one on the rising edge that completes each fourth enabled cycle.
- R2: active_o is 1 exactly when col_o is below 200 and line_o is below 600. An unbroken active run lasts 800 clock cycles (200 steps).
- R3: hsync_o is 0 for columns 210 through 241, a run of 32 steps or 128 clock cycles. It is 1 at every other column, so columns 200 through 209 are blank with hsync_o still high.
- R4: col_o wraps from 263 to 0. line_o advances by one at that wrap and at no other time.
- R5: line_o wraps from 627 to 0, so one frame with en_i held high lasts 264 x 628 x 4 clock cycles.
- R6: vsync_o is at its active level for lines 601 through 604 and inactive otherwise. The active level is 0 when VSYNC_ACTIVE_LOW is 1, which is the default, and 1 otherwise.
- R7: A synchronous reset (rst_i high, sampled on the rising edge) clears the divider and both counters. Afterwards col_o=0, line_o=0, hsync_o=1, vsync_o is inactive and active_o=1, whatever en_i is.
- R8: While en_i is low, the divider, col_o, line_o, hsync_o, vsync_o and active_o all hold their values.
- R9: col_o, line_o, hsync_o, vsync_o and active_o all change on the same clock edge, so in every cycle they describe the same position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 40 MHz timing clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Advances the divider when high; freezes all timing state when low |
| hsync_o | output | 1 | Horizontal sync, low during the line sync pulse |
| vsync_o | output | 1 | Vertical sync, active level set by VSYNC_ACTIVE_LOW |
| active_o | output | 1 | High while the current column and line are both visible |
| col_o | output | 9 | Current column, 0 to 263 |
| line_o | output | 10 | Current line, 0 to 627 |

## Verification
A pixel step happens on the rising edge at which the divider completes its fourth enabled cycle. All five outputs change on that same edge, with no further register delay. The bench samples them on the falling edge half a period later. Its reference model advances using the en_i value it drove before that rising edge, so each expected value matches the cycle in which the output is due. Region lengths are measured in clock cycles across a whole frame with en_i held high. The vertical size parameters are reduced so that a full frame fits inside the run, while the horizontal timing keeps its default values.

// File: rtl/scan_timing_pkg.sv
package scan_timing_pkg;

    // Region flags kept per axis: visible span and sync span.
    typedef struct packed {
        logic vis;
        logic sync;
    } zone_t;

    // Counter width able to hold values 0 .. n-1.
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int DIV = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    output logic tick_o
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV > 1) begin : g_count
            localparam logic [W-1:0] LAST = W'(DIV - 1);

            typedef struct packed {
                logic [W-1:0] phase;
            } div_st_t;

            div_st_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (en_i) begin
                    st_d.phase = (st_q.phase == LAST) ? '0 : st_q.phase + 1'b1;
                end
                if (rst_i) begin
                    st_d.phase = '0;
                end
            end

            always_ff @(posedge clk_i) begin
                st_q <= st_d;
            end

            assign tick_o = en_i && (st_q.phase == LAST);

            AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
                st_q.phase <= LAST);                                            // R1
            AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
                !en_i |=> $stable(st_q.phase));                                 // R8
        end else begin : g_pass
            assign tick_o = en_i;
        end
    endgenerate

endmodule

// File: rtl/axis_timer.sv
module axis_timer
    import scan_timing_pkg::*;
#(
    parameter int VIS  = 200,
    parameter int FP   = 10,
    parameter int SYNC = 32,
    parameter int BP   = 22,
    localparam int TOTAL = VIS + FP + SYNC + BP,
    localparam int W     = cnt_width(TOTAL)
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         step_i,
    output logic [W-1:0] cnt_o,
    output zone_t        zone_o,
    output zone_t        zone_nxt_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] LAST     = W'(TOTAL - 1);
    localparam logic [W:0]   VIS_END  = (W+1)'(VIS);
    localparam logic [W:0]   SYN_BEG  = (W+1)'(VIS + FP);
    localparam logic [W:0]   SYN_END  = (W+1)'(VIS + FP + SYNC);

    typedef struct packed {
        logic [W-1:0] cnt;
        zone_t        zone;
    } axis_st_t;

    axis_st_t st_d, st_q;
    logic     wrap;
    logic [W:0] nxt_ext;

    assign wrap = step_i && (st_q.cnt == LAST);

    always_comb begin
        st_d    = st_q;
        nxt_ext = '0;
        if (step_i) begin
            st_d.cnt = wrap ? '0 : st_q.cnt + 1'b1;
            nxt_ext  = {1'b0, st_d.cnt};
            // exact-match edges on the count about to be stored
            if (nxt_ext == VIS_END) st_d.zone.vis  = 1'b0;
            if (nxt_ext == SYN_BEG) st_d.zone.sync = 1'b1;
            if (nxt_ext == SYN_END) st_d.zone.sync = 1'b0;
            if (nxt_ext == '0) begin
                st_d.zone.vis  = 1'b1;
                st_d.zone.sync = 1'b0;
            end
        end
        if (rst_i) begin
            st_d.cnt       = '0;
            st_d.zone.vis  = 1'b1;
            st_d.zone.sync = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign cnt_o      = st_q.cnt;
    assign zone_o     = st_q.zone;
    assign zone_nxt_o = st_d.zone;
    assign wrap_o     = wrap;

    AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.cnt <= LAST);                                                      // R4
    AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        wrap |=> (st_q.cnt == '0));                                             // R4
    AST_VIS_SPAN: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.zone.vis == ({1'b0, st_q.cnt} < VIS_END));                         // R2
    AST_SYNC_SPAN: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.zone.sync == (({1'b0, st_q.cnt} >= SYN_BEG) &&
                           ({1'b0, st_q.cnt} <  SYN_END)));                     // R3
    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !step_i |=> $stable(st_q));                                             // R8

endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
    import scan_timing_pkg::*;
#(
    parameter int CLK_DIV          = 4,
    parameter int H_VIS            = 200,
    parameter int H_FP             = 10,
    parameter int H_SYNC           = 32,
    parameter int H_BP             = 22,
    parameter int V_VIS            = 600,
    parameter int V_FP             = 1,
    parameter int V_SYNC           = 4,
    parameter int V_BP             = 23,
    parameter bit VSYNC_ACTIVE_LOW = 1'b1,
    localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP,
    localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP,
    localparam int HW      = cnt_width(H_TOTAL),
    localparam int VW      = cnt_width(V_TOTAL)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          en_i,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          active_o,
    output logic [HW-1:0] col_o,
    output logic [VW-1:0] line_o
);
    localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);

    logic  tick;
    logic  h_wrap;
    logic  v_wrap;
    zone_t h_zone, h_nxt;
    zone_t v_zone, v_nxt;

    tick_divider #(
        .DIV    (CLK_DIV)
    ) u_div (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (en_i),
        .tick_o (tick)
    );

    axis_timer #(
        .VIS        (H_VIS),
        .FP         (H_FP),
        .SYNC       (H_SYNC),
        .BP         (H_BP)
    ) u_haxis (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .step_i     (tick),
        .cnt_o      (col_o),
        .zone_o     (h_zone),
        .zone_nxt_o (h_nxt),
        .wrap_o     (h_wrap)
    );

    axis_timer #(
        .VIS        (V_VIS),
        .FP         (V_FP),
        .SYNC       (V_SYNC),
        .BP         (V_BP)
    ) u_vaxis (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .step_i     (h_wrap),
        .cnt_o      (line_o),
        .zone_o     (v_zone),
        .zone_nxt_o (v_nxt),
        .wrap_o     (v_wrap)
    );

    // Combined visible flag kept in its own register.
    typedef struct packed {
        logic active;
    } top_st_t;

    top_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            st_d.active = h_nxt.vis && v_nxt.vis;
        end
        if (rst_i) begin
            st_d.active = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign active_o = st_q.active;
    assign hsync_o  = ~h_zone.sync;

    generate
        if (VSYNC_ACTIVE_LOW) begin : g_vs_low
            assign vsync_o = ~v_zone.sync;
        end else begin : g_vs_high
            assign vsync_o = v_zone.sync;
        end
    endgenerate

    AST_ACTIVE_BOTH: assert property (@(posedge clk_i) disable iff (rst_i)
        active_o == (h_zone.vis && v_zone.vis));                                // R2
    AST_LINE_STEADY: assert property (@(posedge clk_i) disable iff (rst_i)
        !(tick && (col_o == H_LAST)) |=> $stable(line_o));                      // R4
    AST_FRAME_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
        v_wrap |=> (line_o == '0) && (col_o == '0));                            // R5
    AST_RESET_STATE: assert property (@(posedge clk_i)
        $past(rst_i) |-> (col_o == '0) && (line_o == '0) && hsync_o && active_o); // R7
    AST_HOLD_OUTS: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> $stable(col_o) && $stable(line_o) && $stable(active_o));      // R8

endmodule

// File: tb/sim_scan_timing_gen.sv
`timescale 1ns/1ps
module sim_scan_timing_gen;
    localparam int DIV = 4;
    localparam int HV = 200, HF = 10, HS = 32, HB = 22;
    localparam int VV = 20,  VF = 1,  VS = 4,  VB = 3;
    localparam int HT = HV + HF + HS + HB;
    localparam int VT = VV + VF + VS + VB;
    localparam int FRAME = HT * VT * DIV;
    localparam int LIMIT = 200000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic hsync, vsync, active;
    logic [8:0] col;
    logic [4:0] line;

    int nchk = 0;
    int nfail = 0;
    int ncyc = 0;
    bit done = 1'b0;

    int mdiv = 0, mcol = 0, mline = 0;

    bit mon_on = 1'b0;
    int run_hs = 0, run_act = 0, run_vs = 0;
    bit prev_hs = 1'b1, prev_act = 1'b1, prev_vs = 1'b1;

    always #4 clk = ~clk;

    scan_timing_gen #(
        .CLK_DIV (DIV),
        .H_VIS (HV), .H_FP (HF), .H_SYNC (HS), .H_BP (HB),
        .V_VIS (VV), .V_FP (VF), .V_SYNC (VS), .V_BP (VB)
    ) u0 (
        .clk_i    (clk),
        .rst_i    (rst),
        .en_i     (en),
        .hsync_o  (hsync),
        .vsync_o  (vsync),
        .active_o (active),
        .col_o    (col),
        .line_o   (line)
    );

    function automatic bit exp_hs(input int c);
        return !((c >= HV + HF) && (c < HV + HF + HS));
    endfunction

    function automatic bit exp_vs(input int l);
        return !((l >= VV + VF) && (l < VV + VF + VS));
    endfunction

    function automatic bit exp_act(input int c, input int l);
        return (c < HV) && (l < VV);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic monitor();
        if (!hsync) run_hs++;
        else if (!prev_hs) begin chk(run_hs == HS*DIV, "R3 hsync low length", run_hs, HS*DIV); run_hs = 0; end
        if (active) run_act++;
        else if (prev_act) begin chk(run_act == HV*DIV, "R2 active length", run_act, HV*DIV); run_act = 0; end
        if (!vsync) run_vs++;
        else if (!prev_vs) begin chk(run_vs == VS*HT*DIV, "R6 vsync length", run_vs, VS*HT*DIV); run_vs = 0; end
        prev_hs = hsync; prev_act = active; prev_vs = vsync;
    endtask

    task automatic cycle(input bit rst_v, input bit en_v);
        @(negedge clk);
        ncyc++;
        chk(col == 9'(mcol), "R1 col", int'(col), mcol);
        chk(line == 5'(mline), "R4 line", int'(line), mline);
        chk(hsync == exp_hs(mcol), "R3 hsync", int'(hsync), int'(exp_hs(mcol)));
        chk(vsync == exp_vs(mline), "R6 vsync", int'(vsync), int'(exp_vs(mline)));
        chk(active == exp_act(mcol, mline), "R2 R9 active", int'(active), int'(exp_act(mcol, mline)));
        if (mon_on) monitor();
        rst = rst_v;
        en  = en_v;
        if (rst_v) begin
            mdiv = 0; mcol = 0; mline = 0;
        end else if (en_v) begin
            if (mdiv == DIV - 1) begin
                mdiv = 0;
                if (mcol == HT - 1) begin
                    mcol = 0;
                    mline = (mline == VT - 1) ? 0 : mline + 1;
                end else begin
                    mcol++;
                end
            end else begin
                mdiv++;
            end
        end
    endtask

    initial begin
        void'($urandom(32'd5417));
        // reset held, R7 reset state
        repeat (3) cycle(1'b1, 1'b0);
        chk(col == 9'd0 && line == 5'd0, "R7 counters cleared", int'(col), 0);
        chk(hsync && vsync && active, "R7 flags at reset", {hsync, vsync, active}, 3'b111);

        // full frame with enable held, region lengths (R2 R3 R6) and R5 wrap
        mon_on = 1'b1;
        for (int i = 0; i < FRAME; i++) begin
            cycle(1'b0, 1'b1);
            if (i == FRAME - 2) begin
                chk(int'(line) == VT - 1 && int'(col) == HT - 1, "R5 last position",
                    int'(line), VT - 1);
            end
        end
        mon_on = 1'b0;
        cycle(1'b0, 1'b1);
        chk(col == 9'd0 && line == 5'd0, "R5 frame wrap", int'(line), 0);

        // constrained random enable with rare resets
        for (int i = 0; i < 20000; i++) begin
            cycle(($urandom_range(0, 4999) == 0), ($urandom_range(0, 3) != 0));
        end

        // R8: enable low holds everything
        begin
            logic [8:0] c0;
            logic [4:0] l0;
            logic h0, v0, a0;
            cycle(1'b0, 1'b0);
            c0 = col; l0 = line; h0 = hsync; v0 = vsync; a0 = active;
            for (int i = 0; i < 12; i++) begin
                cycle(1'b0, 1'b0);
                chk(col == c0 && line == l0, "R8 counters hold", int'(col), int'(c0));
                chk({hsync, vsync, active} == {h0, v0, a0}, "R8 flags hold",
                    {hsync, vsync, active}, {h0, v0, a0});
            end
        end

        // directed: run into horizontal sync, then reset mid-line (R7)
        for (int i = 0; i < (HV + HF + 3) * DIV; i++) cycle(1'b0, 1'b1);
        cycle(1'b1, 1'b1);
        cycle(1'b1, 1'b1);
        chk(col == 9'd0 && line == 5'd0, "R7 mid-run reset counters", int'(col), 0);
        chk(hsync && vsync && active, "R7 mid-run reset flags", {hsync, vsync, active}, 3'b111);
        for (int i = 0; i < 50; i++) cycle(1'b0, 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        #(LIMIT * 8);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog expired after %0d cycles expected completion", ncyc);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule